// File: doc/BRIEF.md
# Self-Rescheduling Two-Channel Compare Timer

This block keeps a 10-bit counter that moves forward by one on every clock in which the tick enable input is high, and wraps from 1023 back to 0. Two compare channels watch it. Each channel has its own target value, its own increment and a small configuration word. A channel is hit when the counter takes the value equal to its target. A hit can set a sticky interrupt flag, and it can also act on a dedicated output pin.

After each hit the channel adds its increment to its own target, modulo 1024. A channel with a nonzero increment therefore produces a regular stream of events with no further writes. A channel with a zero increment keeps its target and fires once on every full turn of the counter. The tick source and the bus address decoder sit outside this block. Software writes the target, increment and configuration of each channel through a simple write port. It clears a flag by pulsing the matching bit of the clear input.

Top module: `step_timer`

## Requirements
- R1: After reset the counter, every target, increment and configuration word, both pins and both flags are zero. An unconfigured channel therefore never fires.
- R2: The counter increments by one, modulo 1024, only in cycles where `tickEn` is high. In other cycles it holds its value and no channel can be hit.
- R3: A channel is hit in a cycle where `tickEn` is high, the channel is enabled (configuration bit 0) and the incremented counter value equals the channel's target. The flag is set at that clock edge only if interrupt enable (configuration bit 1) is 1.
- R4: On a hit the pin is updated according to configuration bits 3:2. The codes are 00 keep, 01 drive high, 10 drive low and 11 invert. Without a hit the pin does not change.
- R5: On a hit the target becomes target plus increment, modulo 1024. An increment of zero leaves the target unchanged, so the channel fires again after 1024 ticks.
- R6: Flags stay set until a 1 is written to the matching `irqClr` bit. If a hit that sets the flag occurs in the same cycle as a clear, the flag stays set.
- R7: A disabled channel is never hit. Its flag, its pin and its target are left unchanged while ticks pass its target.
- R8: The two channels act independently. A write, hit or clear on one channel does not affect the other channel.
- R9: Writes use `wrAddr[2]` to select the channel and `wrAddr[1:0]` to select the register: 00 target, 01 increment, 10 configuration, 11 ignored. If a target write and a hit occur in the same cycle, the written value replaces the auto-advanced value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | Counter advance enable (prescaled tick) |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Channel and register select |
| wrData | input | 10 | Write data |
| irqClr | input | 2 | Per-channel write-one-to-clear for the flags |
| pinOut | output | 2 | Per-channel event pins |
| irqFlag | output | 2 | Per-channel sticky interrupt flags |

## Verification
The bench drives the counter through the 1023-to-0 wrap in three situations: a zero increment, a target plus increment sum that exceeds 1023, and a channel disabled while the counter passed its target. A design that carried the sum into an eleventh bit, or advanced the target of a disabled channel, would fire one turn too early or never fire at all. It also aims a hit at the same cycle as a flag clear and at the same cycle as a target write. A wrong priority there would lose an interrupt, or schedule the next event from a stale target. It runs every pin code on two successive hits, compares on the incremented count value, and checks that ticks stopped by `tickEn` never produce an event. Mistakes in those areas show up as an early event, a lost event or a pin stuck at a wrong level.

// File: rtl/step_timer_pkg.sv
package step_timer_pkg;

  localparam int unsigned TMR_W  = 10;
  localparam int unsigned TMR_CH = 2;
  localparam int unsigned SEL_W  = 2;
  localparam int unsigned CH_W   = (TMR_CH > 1) ? $clog2(TMR_CH) : 1;
  localparam int unsigned ADDR_W = CH_W + SEL_W;

  typedef enum logic [SEL_W-1:0] {
    FLD_MATCH = 2'd0,
    FLD_STEP  = 2'd1,
    FLD_CFG   = 2'd2,
    FLD_NONE  = 2'd3
  } fld_e;

  typedef enum logic [1:0] {
    PIN_KEEP = 2'd0,
    PIN_SET  = 2'd1,
    PIN_CLR  = 2'd2,
    PIN_TGL  = 2'd3
  } pin_act_e;

  typedef struct packed {
    logic     en;
    logic     irqEn;
    pin_act_e act;
  } ch_cfg_t;

  // strobes from control to datapath
  typedef struct packed {
    logic              tick;
    logic [TMR_CH-1:0] hit;
    logic [TMR_CH-1:0] clr;
    logic [TMR_CH-1:0] wrMatch;
    logic [TMR_CH-1:0] wrStep;
    logic [TMR_CH-1:0] wrCfg;
  } strobe_t;

endpackage

// File: rtl/step_timer_ctrl.sv
module step_timer_ctrl
  import step_timer_pkg::*;
(
  input  logic                          tickEn,
  input  logic                          wrEn,
  input  logic [ADDR_W-1:0]             wrAddr,
  input  logic [TMR_CH-1:0]             irqClr,
  input  logic [TMR_W-1:0]              cnt,
  input  logic [TMR_CH-1:0][TMR_W-1:0]  matchVec,
  input  logic [TMR_CH-1:0]             enVec,
  output strobe_t                       strb
);

  logic [TMR_W-1:0]  cntNext;
  logic [CH_W-1:0]   chSel;
  fld_e              fld;
  logic [TMR_CH-1:0] hitV;
  logic [TMR_CH-1:0] wrMatchV;
  logic [TMR_CH-1:0] wrStepV;
  logic [TMR_CH-1:0] wrCfgV;

  // compare against the value the counter is about to take
  assign cntNext = cnt + TMR_W'(1);
  assign chSel   = wrAddr[ADDR_W-1:SEL_W];
  assign fld     = fld_e'(wrAddr[SEL_W-1:0]);

  for (genvar c = 0; c < TMR_CH; c++) begin : g_ch
    logic selMe;
    assign selMe       = wrEn && (chSel == CH_W'(c));
    assign hitV[c]     = tickEn && enVec[c] && (cntNext == matchVec[c]);
    assign wrMatchV[c] = selMe && (fld == FLD_MATCH);
    assign wrStepV[c]  = selMe && (fld == FLD_STEP);
    assign wrCfgV[c]   = selMe && (fld == FLD_CFG);
  end

  assign strb = '{
    tick:    tickEn,
    hit:     hitV,
    clr:     irqClr,
    wrMatch: wrMatchV,
    wrStep:  wrStepV,
    wrCfg:   wrCfgV
  };

endmodule

// File: rtl/step_timer_dp.sv
module step_timer_dp
  import step_timer_pkg::*;
(
  input  logic                          clk,
  input  logic                          rstN,
  input  strobe_t                       strb,
  input  logic [TMR_W-1:0]              wrData,
  output logic [TMR_W-1:0]              cnt,
  output logic [TMR_CH-1:0][TMR_W-1:0]  matchVec,
  output logic [TMR_CH-1:0]             enVec,
  output logic [TMR_CH-1:0]             pinOut,
  output logic [TMR_CH-1:0]             irqFlag
);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (strb.tick) begin
      cnt <= cnt + TMR_W'(1);
    end
  end

  for (genvar c = 0; c < TMR_CH; c++) begin : g_ch
    logic [TMR_W-1:0] matchQ;
    logic [TMR_W-1:0] stepQ;
    ch_cfg_t          cfgQ;
    logic             pinQ;
    logic             flagQ;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        matchQ <= '0;
        stepQ  <= '0;
        cfgQ   <= '0;
        pinQ   <= 1'b0;
        flagQ  <= 1'b0;
      end else begin
        // a software write outranks the automatic advance
        if (strb.wrMatch[c]) begin
          matchQ <= wrData;
        end else if (strb.hit[c] && (stepQ != '0)) begin
          matchQ <= matchQ + stepQ;
        end

        if (strb.wrStep[c]) begin
          stepQ <= wrData;
        end

        if (strb.wrCfg[c]) begin
          cfgQ <= '{en: wrData[0], irqEn: wrData[1], act: pin_act_e'(wrData[3:2])};
        end

        // a new event outranks the clear
        if (strb.hit[c] && cfgQ.irqEn) begin
          flagQ <= 1'b1;
        end else if (strb.clr[c]) begin
          flagQ <= 1'b0;
        end

        if (strb.hit[c]) begin
          case (cfgQ.act)
            PIN_SET: pinQ <= 1'b1;
            PIN_CLR: pinQ <= 1'b0;
            PIN_TGL: pinQ <= ~pinQ;
            default: pinQ <= pinQ;
          endcase
        end
      end
    end

    assign matchVec[c] = matchQ;
    assign enVec[c]    = cfgQ.en;
    assign pinOut[c]   = pinQ;
    assign irqFlag[c]  = flagQ;
  end

endmodule

// File: rtl/step_timer.sv
module step_timer
  import step_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [TMR_W-1:0]  wrData,
  input  logic [TMR_CH-1:0] irqClr,
  output logic [TMR_CH-1:0] pinOut,
  output logic [TMR_CH-1:0] irqFlag
);

  strobe_t                       strb;
  logic [TMR_W-1:0]              cnt;
  logic [TMR_CH-1:0][TMR_W-1:0]  matchVec;
  logic [TMR_CH-1:0]             enVec;
  logic [TMR_CH-1:0]             hitVec;

  assign hitVec = strb.hit;

  step_timer_ctrl u_ctrl (
    .tickEn   (tickEn),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .irqClr   (irqClr),
    .cnt      (cnt),
    .matchVec (matchVec),
    .enVec    (enVec),
    .strb     (strb)
  );

  step_timer_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .cnt      (cnt),
    .matchVec (matchVec),
    .enVec    (enVec),
    .pinOut   (pinOut),
    .irqFlag  (irqFlag)
  );

endmodule

// File: rtl/step_timer_chk.sv
module step_timer_chk
  import step_timer_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              tickEn,
  input logic [TMR_CH-1:0] irqClr,
  input logic [TMR_CH-1:0] pinOut,
  input logic [TMR_CH-1:0] irqFlag,
  input logic [TMR_CH-1:0] hitVec,
  input logic [TMR_CH-1:0] enVec
);

  for (genvar c = 0; c < TMR_CH; c++) begin : g_chk
    p_hit_needs_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
      hitVec[c] |-> tickEn);

    p_flag_from_hit_r3: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irqFlag[c]) |-> $past(hitVec[c]));

    p_pin_quiet_r4: assert property (@(posedge clk) disable iff (!rstN)
      !hitVec[c] |=> $stable(pinOut[c]));

    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
      (irqFlag[c] && !irqClr[c]) |=> irqFlag[c]);

    p_flag_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
      $fell(irqFlag[c]) |-> $past(irqClr[c]));

    p_off_no_hit_r7: assert property (@(posedge clk) disable iff (!rstN)
      !enVec[c] |-> !hitVec[c]);
  end

endmodule

bind step_timer step_timer_chk u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .tickEn  (tickEn),
  .irqClr  (irqClr),
  .pinOut  (pinOut),
  .irqFlag (irqFlag),
  .hitVec  (hitVec),
  .enVec   (enVec)
);

// File: tb/sim_step_timer.sv
`timescale 1ns/1ps
module sim_step_timer;
  import step_timer_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              tickEn = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] wrAddr = '0;
  logic [TMR_W-1:0]  wrData = '0;
  logic [TMR_CH-1:0] irqClr = '0;
  logic [TMR_CH-1:0] pinOut;
  logic [TMR_CH-1:0] irqFlag;

  int  checks = 0;
  int  errors = 0;
  bit  finished = 1'b0;

  always #10 clk = ~clk;

  step_timer u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .irqClr(irqClr), .pinOut(pinOut), .irqFlag(irqFlag)
  );

  // {pin code[3:2], pin after first hit[1], pin after second hit[0]}
  localparam logic [3:0] ACT_TBL [4] = '{4'b00_0_0, 4'b01_1_1, 4'b10_0_0, 4'b11_1_0};

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; tickEn = 1'b0; wrEn = 1'b0; irqClr = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic tick(input int n);
    if (n > 0) begin
      tickEn = 1'b1;
      repeat (n) @(negedge clk);
      tickEn = 1'b0;
    end
  endtask

  task automatic wr(input int ch, input logic [1:0] fld, input int data);
    wrEn = 1'b1;
    wrAddr = {CH_W'(ch), fld};
    wrData = TMR_W'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic clr(input logic [TMR_CH-1:0] mask);
    irqClr = mask;
    @(negedge clk);
    irqClr = '0;
  endtask

  function automatic int cfgWord(input bit en, input bit irq, input logic [1:0] act);
    return int'({act, irq, en});
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired got 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: reset state and unconfigured channels stay silent
    doReset();
    check("R1 pins after reset", pinOut, 0);
    check("R1 flags after reset", irqFlag, 0);
    tick(5);
    check("R1 unconfigured flags", irqFlag, 0);

    // R3 R4 R5: table of pin codes over two successive hits
    for (int i = 0; i < 4; i++) begin
      doReset();
      wr(0, 2'b00, 5);
      wr(0, 2'b01, 3);
      wr(0, 2'b10, cfgWord(1, 1, ACT_TBL[i][3:2]));
      tick(4);
      check("R3 no hit before target", irqFlag[0], 0);
      check("R4 pin before target", pinOut[0], 0);
      tick(1);
      check("R3 flag on hit", irqFlag[0], 1);
      check("R4 pin after first hit", pinOut[0], ACT_TBL[i][1]);
      clr(2'b01);
      check("R6 flag cleared", irqFlag[0], 0);
      tick(2);
      check("R5 no early second hit", irqFlag[0], 0);
      tick(1);
      check("R5 second hit at target+step", irqFlag[0], 1);
      check("R4 pin after second hit", pinOut[0], ACT_TBL[i][0]);
    end

    // R4: drive-low code after a drive-high
    doReset();
    wr(0, 2'b00, 2); wr(0, 2'b01, 2); wr(0, 2'b10, cfgWord(1, 0, 2'b01));
    tick(2);
    check("R4 set code", pinOut[0], 1);
    wr(0, 2'b10, cfgWord(1, 0, 2'b10));
    tick(2);
    check("R4 clear code", pinOut[0], 0);

    // R3: interrupt enable off, pin still acts
    doReset();
    wr(0, 2'b00, 3); wr(0, 2'b10, cfgWord(1, 0, 2'b11));
    tick(3);
    check("R3 flag with irq disabled", irqFlag[0], 0);
    check("R3 pin with irq disabled", pinOut[0], 1);

    // R2: ticks gated by tickEn
    doReset();
    wr(0, 2'b00, 2); wr(0, 2'b10, cfgWord(1, 1, 2'b00));
    tick(1);
    repeat (10) @(negedge clk);
    check("R2 counter holds without tick", irqFlag[0], 0);
    tick(1);
    check("R2 second tick reaches target", irqFlag[0], 1);

    // R5 R2: zero step, counter wrap
    doReset();
    wr(0, 2'b00, 0); wr(0, 2'b10, cfgWord(1, 1, 2'b00));
    tick(1023);
    check("R2 no hit before wrap", irqFlag[0], 0);
    tick(1);
    check("R2 hit on wrap to zero", irqFlag[0], 1);
    clr(2'b01);
    tick(1023);
    check("R5 zero step no early hit", irqFlag[0], 0);
    tick(1);
    check("R5 zero step refires after full turn", irqFlag[0], 1);

    // R5: sum wraps modulo 1024 (1020 + 10 -> 6)
    doReset();
    wr(0, 2'b00, 1020); wr(0, 2'b01, 10); wr(0, 2'b10, cfgWord(1, 1, 2'b00));
    tick(1020);
    check("R5 first hit at 1020", irqFlag[0], 1);
    clr(2'b01);
    tick(9);
    check("R5 wrapped target not early", irqFlag[0], 0);
    tick(1);
    check("R5 wrapped target hit at 6", irqFlag[0], 1);

    // R6: hit and clear in the same cycle, clear with no flag
    doReset();
    wr(0, 2'b00, 4); wr(0, 2'b10, cfgWord(1, 1, 2'b00));
    clr(2'b01);
    check("R6 clear on idle flag", irqFlag[0], 0);
    tick(3);
    tickEn = 1'b1; irqClr = 2'b01;
    @(negedge clk);
    tickEn = 1'b0; irqClr = '0;
    check("R6 hit wins over clear", irqFlag[0], 1);

    // R7: disabled channel leaves flag, pin and target untouched
    doReset();
    wr(0, 2'b00, 6); wr(0, 2'b01, 1); wr(0, 2'b10, cfgWord(0, 1, 2'b01));
    tick(6);
    check("R7 disabled flag", irqFlag[0], 0);
    check("R7 disabled pin", pinOut[0], 0);
    wr(0, 2'b10, cfgWord(1, 1, 2'b01));
    tick(1023);
    check("R7 target not advanced while off", irqFlag[0], 0);
    tick(1);
    check("R7 original target hit after turn", irqFlag[0], 1);
    check("R7 pin set on late hit", pinOut[0], 1);

    // R8: independent channels
    doReset();
    wr(0, 2'b00, 3); wr(0, 2'b01, 5); wr(0, 2'b10, cfgWord(1, 1, 2'b00));
    wr(1, 2'b00, 5); wr(1, 2'b01, 4); wr(1, 2'b10, cfgWord(1, 0, 2'b11));
    tick(3);
    check("R8 ch0 flag only", irqFlag, 1);
    check("R8 pins untouched", pinOut, 0);
    clr(2'b01);
    tick(2);
    check("R8 ch1 pin toggles alone", pinOut, 2);
    check("R8 flags after ch1 hit", irqFlag, 0);
    tick(3);
    check("R8 ch0 second hit", irqFlag, 1);
    check("R8 ch1 pin held", pinOut, 2);
    tick(1);
    check("R8 ch1 second toggle", pinOut, 0);

    // R9: target write in the hit cycle wins; unused field ignored
    doReset();
    wr(0, 2'b00, 4); wr(0, 2'b01, 2); wr(0, 2'b10, cfgWord(1, 1, 2'b00));
    wr(0, 2'b11, 1);
    tick(3);
    tickEn = 1'b1; wrEn = 1'b1; wrAddr = {CH_W'(0), 2'b00}; wrData = TMR_W'(10);
    @(negedge clk);
    tickEn = 1'b0; wrEn = 1'b0;
    check("R9 hit still flagged", irqFlag[0], 1);
    clr(2'b01);
    tick(2);
    check("R9 advanced value discarded", irqFlag[0], 0);
    tick(4);
    check("R9 written target hit at 10", irqFlag[0], 1);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule